// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block drives the active-low read and write strobes of one parallel ATA channel. It serves PIO and multiword-DMA style data transfers and task-file register accesses. Each of the channel's two drives has its own 32-bit timing word in a small local store. A host request names the direction, the access kind, the drive, and for data transfers a burst length. When the block accepts a request, it latches the timing fields it needs. It then holds the strobe high for a setup interval, pulses the selected strobe low once per word with a programmed inactive gap between pulses, and raises a one-cycle completion pulse when the last low pulse ends.

Every duration field holds a count n and means n+1 clocks. Task-file accesses take their active, inactive and setup counts from fields that are separate from the fields used by data transfers. The four flag bits at the top of the timing word are kept in the store and can be read back, but they have no effect on strobe timing.

Top module: `ata_pio_strobe_gen`

## Requirements
- R1: After a synchronous reset, rd_n and wr_n are high, req_ready is high and done is low.
- R2: A write with cfg_we stores all 32 bits of cfg_wdata for drive cfg_sel. cfg_rdata presents the stored word of drive cfg_sel one clock later, including bits 31:28.
- R3: After a request is accepted, both strobes stay high for (setup+1) clocks before the first low pulse. For a data transfer, setup is bits 24:22 of the timing word. For a task-file access, setup is bits 27:25.
- R4: In a data transfer, each low pulse lasts (bits 8:4)+1 clocks, and consecutive pulses are separated by (bits 3:0)+1 high clocks.
- R5: In a task-file access (req_taskfile=1), the low pulse lasts (bits 17:13)+1 clocks and the inactive field is bits 12:9. The access is always a single pulse, whatever req_words_m1 holds.
- R6: A data transfer produces req_words_m1+1 low pulses, with the setup applied once. done is high for exactly one clock, in the clock in which the strobe returns high after the last pulse. No trailing gap comes first.
- R7: req_write=1 pulses only wr_n and req_write=0 pulses only rd_n. The other strobe stays high, and the two strobes are never low together.
- R8: Bits 31:28 of the timing word do not change any strobe duration.
- R9: The timing word, direction, access kind and drive are taken when the request is accepted. Changes afterwards, including a store write to the active drive in the accept cycle itself, do not alter the running sequence.
- R10: req_ready is low from the clock after acceptance up to the done clock. A req_valid seen while req_ready is low is dropped and produces no strobe activity.
- R11: A synchronous reset during a sequence returns both strobes high and req_ready high, and no further pulses follow.
- R12: req_drive selects which drive's stored word times the sequence (0 or 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the timing store |
| cfg_sel | input | DSEL_W | Drive index for timing store write and read-back |
| cfg_wdata | input | 32 | Timing word to store |
| cfg_rdata | output | 32 | Registered read-back of the word for cfg_sel |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | High when idle and able to accept |
| req_write | input | 1 | 1 = write strobe, 0 = read strobe |
| req_taskfile | input | 1 | 1 = task-file register access, 0 = data transfer |
| req_drive | input | DSEL_W | Drive whose timing word is used |
| req_words_m1 | input | LEN_W | Data burst length minus one |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-clock pulse at sequence end |

## Verification
Two cases can fall in the same clock. In the first, a store write lands on the drive whose request is being accepted. The bench drives cfg_we and req_valid at the same edge and then measures a pulse shape that must match the old word, while the read-back shows the new word. In the second, a request arrives while a sequence is still running. The bench pulses req_valid in mid-sequence and requires that no extra strobe activity appears after done. Each sequence is measured at falling edges by its setup run, its pulse widths, its gaps, the pulse count and the clock in which done appears.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  localparam int TW_W   = 32;
  localparam int CNT_W  = 5;

  localparam int D_INACT_LSB = 0;
  localparam int D_INACT_W   = 4;
  localparam int D_ACT_LSB   = 4;
  localparam int D_ACT_W     = 5;
  localparam int C_INACT_LSB = 9;
  localparam int C_INACT_W   = 4;
  localparam int C_ACT_LSB   = 13;
  localparam int C_ACT_W     = 5;
  localparam int D_SETUP_LSB = 22;
  localparam int T_SETUP_LSB = 25;
  localparam int SETUP_W     = 3;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] act;
    logic [CNT_W-1:0] inact;
  } cyc_timing_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_LOW,
    PH_GAP
  } phase_t;

endpackage

// File: rtl/ata_timing_store.sv
module ata_timing_store #(
  parameter int NUM_DRIVES = 2,
  parameter int DSEL_W     = 1,
  parameter int TW_W       = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [DSEL_W-1:0] sel,
  input  logic [TW_W-1:0]   wdata,
  output logic [TW_W-1:0]   rdata,
  input  logic [DSEL_W-1:0] req_sel,
  output logic [TW_W-1:0]   req_word
);

  logic [TW_W-1:0] mem [NUM_DRIVES];
  logic [TW_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[sel] <= wdata;
    end
    rdata_q <= mem[sel];
  end

  assign rdata    = rdata_q;
  assign req_word = mem[req_sel];

endmodule

// File: rtl/ata_timing_decode.sv
module ata_timing_decode
  import ata_pio_pkg::*;
(
  input  logic [TW_W-1:0] word,
  input  logic            taskfile,
  output cyc_timing_t     timing
);

  logic [CNT_W-1:0] d_act, d_inact, d_setup;
  logic [CNT_W-1:0] c_act, c_inact, c_setup;
  logic             unused_flag_bits;

  assign d_act   = CNT_W'(word[D_ACT_LSB   +: D_ACT_W]);
  assign d_inact = CNT_W'(word[D_INACT_LSB +: D_INACT_W]);
  assign d_setup = CNT_W'(word[D_SETUP_LSB +: SETUP_W]);
  assign c_act   = CNT_W'(word[C_ACT_LSB   +: C_ACT_W]);
  assign c_inact = CNT_W'(word[C_INACT_LSB +: C_INACT_W]);
  assign c_setup = CNT_W'(word[T_SETUP_LSB +: SETUP_W]);

  // mode flags and the high-speed field play no part in strobe timing
  assign unused_flag_bits = ^{word[31:28], word[21:18]};

  always_comb begin
    if (taskfile) begin
      timing.setup = c_setup;
      timing.act   = c_act;
      timing.inact = c_inact;
    end else begin
      timing.setup = d_setup;
      timing.act   = d_act;
      timing.inact = d_inact;
    end
  end

endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             write,
  input  logic             taskfile,
  input  logic [LEN_W-1:0] words_m1,
  input  cyc_timing_t      timing,
  output logic             busy,
  output logic             done,
  output logic             rd_n,
  output logic             wr_n
);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] act_q, inact_q;
  logic [LEN_W-1:0] rem;
  logic             wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      act_q   <= '0;
      inact_q <= '0;
      rem     <= '0;
      wr_q    <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase   <= PH_SETUP;
            busy    <= 1'b1;
            cnt     <= timing.setup;
            act_q   <= timing.act;
            inact_q <= timing.inact;
            wr_q    <= write;
            rem     <= taskfile ? '0 : words_m1;
          end
        end
        PH_SETUP, PH_GAP: begin
          if (cnt == '0) begin
            phase <= PH_LOW;
            cnt   <= act_q;
            rd_n  <= wr_q;
            wr_n  <= ~wr_q;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_LOW: begin
          if (cnt == '0) begin
            rd_n <= 1'b1;
            wr_n <= 1'b1;
            if (rem == '0) begin
              phase <= PH_IDLE;
              busy  <= 1'b0;
              done  <= 1'b1;
            end else begin
              phase <= PH_GAP;
              cnt   <= inact_q;
              rem   <= rem - LEN_W'(1);
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ata_pio_strobe_gen.sv
module ata_pio_strobe_gen
  import ata_pio_pkg::*;
#(
  parameter int NUM_DRIVES = 2,
  parameter int DSEL_W     = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1,
  parameter int LEN_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [DSEL_W-1:0] cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_taskfile,
  input  logic [DSEL_W-1:0] req_drive,
  input  logic [LEN_W-1:0]  req_words_m1,
  output logic              rd_n,
  output logic              wr_n,
  output logic              done
);

  logic [TW_W-1:0] sel_word;
  cyc_timing_t     sel_timing;
  logic            busy;
  logic            start;

  assign req_ready = ~busy;
  assign start     = req_valid & ~busy;

  ata_timing_store #(
    .NUM_DRIVES (NUM_DRIVES),
    .DSEL_W     (DSEL_W),
    .TW_W       (TW_W)
  ) u_store (
    .clk      (clk),
    .we       (cfg_we),
    .sel      (cfg_sel),
    .wdata    (cfg_wdata),
    .rdata    (cfg_rdata),
    .req_sel  (req_drive),
    .req_word (sel_word)
  );

  ata_timing_decode u_decode (
    .word     (sel_word),
    .taskfile (req_taskfile),
    .timing   (sel_timing)
  );

  ata_pio_seq #(
    .LEN_W (LEN_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .write    (req_write),
    .taskfile (req_taskfile),
    .words_m1 (req_words_m1),
    .timing   (sel_timing),
    .busy     (busy),
    .done     (done),
    .rd_n     (rd_n),
    .wr_n     (wr_n)
  );

endmodule

// File: rtl/ata_pio_strobe_gen_chk.sv
module ata_pio_strobe_gen_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic rd_n,
  input logic wr_n,
  input logic done
);

  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q === 1'b1) begin
      AST_RESET_IDLE: assert (rd_n && wr_n && req_ready && !done); // R11
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n)); // R7

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (rd_n && wr_n)); // R1

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_DONE_STROBES_UP: assert property (@(posedge clk) disable iff (rst)
    done |-> (rd_n && wr_n && req_ready)); // R6

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R10

endmodule

bind ata_pio_strobe_gen ata_pio_strobe_gen_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .done      (done)
);

// File: tb/ata_pio_strobe_gen_tb.sv
module ata_pio_strobe_gen_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_taskfile = 1'b0;
  logic [0:0]  req_drive = '0;
  logic [3:0]  req_words_m1 = '0;
  logic        rd_n, wr_n, done;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  ata_pio_strobe_gen u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_taskfile(req_taskfile),
    .req_drive(req_drive), .req_words_m1(req_words_m1),
    .rd_n(rd_n), .wr_n(wr_n), .done(done)
  );

  // {write, taskfile, drive, pad, words_m1, timing word}
  localparam int NV = 7;
  localparam logic [39:0] VEC [NV] = '{
    {4'b0000, 4'd0,  32'h00400032},
    {4'b1010, 4'd3,  32'h00800051},
    {4'b0100, 4'd5,  32'h05408697},
    {4'b1110, 4'd0,  32'h00000020},
    {4'b1000, 4'd2,  32'h00000000},
    {4'b0010, 4'd1,  32'hF1C001FF},
    {4'b1000, 4'd15, 32'h50000010}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  task automatic cfg_write(input bit drv, input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = drv; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_seq(input bit wr, input bit tf, input bit drv,
                         input logic [3:0] m1, input logic [31:0] w,
                         input bit same_we, input logic [31:0] same_word,
                         input string tag);
    int s, a, g, n;
    int hi, lo, pulses, setup_seen, bad_lo, bad_gap, oth, rdy_bad, done_hi;
    bit dn, cur, other;
    s = tf ? int'(w[27:25]) : int'(w[24:22]);
    a = tf ? int'(w[17:13]) : int'(w[8:4]);
    g = tf ? int'(w[12:9])  : int'(w[3:0]);
    n = tf ? 1 : int'(m1) + 1;
    hi = 0; lo = 0; pulses = 0; setup_seen = -1; bad_lo = 0; bad_gap = 0;
    oth = 0; rdy_bad = 0; done_hi = -1; dn = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_taskfile = tf;
    req_drive = drv; req_words_m1 = m1;
    if (same_we) begin
      cfg_we = 1'b1; cfg_sel = drv; cfg_wdata = same_word;
    end
    @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    req_write = ~wr; req_taskfile = ~tf; req_drive = ~drv; req_words_m1 = ~m1;
    for (int k = 0; k < 3000; k++) begin
      cur   = wr ? wr_n : rd_n;
      other = wr ? rd_n : wr_n;
      if (!cur) begin
        if (lo == 0) begin
          pulses++;
          if (pulses == 1) setup_seen = hi;
          else if (hi != g + 1) bad_gap++;
        end
        lo++; hi = 0;
      end else begin
        if (lo > 0) begin
          if (lo != a + 1) bad_lo++;
          lo = 0;
        end
        hi++;
      end
      if (!other) oth++;
      if (done) begin
        dn = 1'b1; done_hi = hi;
        break;
      end
      if (req_ready) rdy_bad++;
      @(negedge clk);
    end
    chk(setup_seen == s + 1, "R3", {tag, " setup clocks"}, setup_seen, s + 1);
    chk(pulses == n, tf ? "R5" : "R6", {tag, " pulse count"}, pulses, n);
    chk(bad_lo == 0, tf ? "R5" : "R4", {tag, " low width errors"}, bad_lo, 0);
    chk(bad_gap == 0, "R4", {tag, " gap errors"}, bad_gap, 0);
    chk(dn && done_hi == 1, "R6", {tag, " done placement"}, done_hi, 1);
    chk(oth == 0, "R7", {tag, " other strobe low"}, oth, 0);
    chk(rdy_bad == 0, "R10", {tag, " ready while busy"}, rdy_bad, 0);
    req_write = 1'b0; req_taskfile = 1'b0; req_drive = '0; req_words_m1 = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(rd_n == 1'b1, "R1", "rd_n after reset", rd_n, 1);
    chk(wr_n == 1'b1, "R1", "wr_n after reset", wr_n, 1);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(done == 1'b0, "R1", "done after reset", done, 0);

    // R2 / R12 read-back of both drives
    cfg_write(1'b0, 32'h1234ABCD);
    cfg_write(1'b1, 32'hF00AB123);
    cfg_sel = 1'b0; @(negedge clk); @(negedge clk);
    chk(cfg_rdata == 32'h1234ABCD, "R2", "drive0 readback", cfg_rdata, 32'h1234ABCD);
    cfg_sel = 1'b1; @(negedge clk); @(negedge clk);
    chk(cfg_rdata == 32'hF00AB123, "R12", "drive1 readback", cfg_rdata, 32'hF00AB123);

    // table walk (R3..R8, R12)
    for (int v = 0; v < NV; v++) begin
      logic [39:0] e;
      e = VEC[v];
      cfg_write(~e[37], ~e[31:0] & 32'h0FFFFFFF);
      cfg_write(e[37], e[31:0]);
      run_seq(e[39], e[38], e[37], e[35:32], e[31:0], 1'b0, 32'h0,
              $sformatf("vec%0d R8 R12", v));
    end

    // R9: word changed mid-sequence
    cfg_write(1'b0, 32'h00800043);
    fork
      run_seq(1'b0, 1'b0, 1'b0, 4'd2, 32'h00800043, 1'b0, 32'h0, "R9 midchange");
      begin
        repeat (5) @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h00000000;
        @(negedge clk);
        cfg_we = 1'b0;
      end
    join

    // R9: store write in the accept cycle itself
    cfg_write(1'b0, 32'h00400021);
    run_seq(1'b1, 1'b0, 1'b0, 4'd1, 32'h00400021, 1'b1, 32'h01C001FF, "R9 samecycle");
    cfg_sel = 1'b0; @(negedge clk); @(negedge clk);
    chk(cfg_rdata == 32'h01C001FF, "R2", "same-cycle write stored", cfg_rdata, 32'h01C001FF);

    // R10: request while busy is dropped
    cfg_write(1'b1, 32'h00C00070);
    fork
      run_seq(1'b1, 1'b0, 1'b1, 4'd0, 32'h00C00070, 1'b0, 32'h0, "R10 refuse");
      begin
        repeat (3) @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
      end
    join
    begin
      int act_cnt;
      act_cnt = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (!rd_n || !wr_n || !req_ready) act_cnt++;
      end
      chk(act_cnt == 0, "R10", "activity after dropped request", act_cnt, 0);
    end

    // R11: reset in mid-pulse
    cfg_write(1'b0, 32'h00000050);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_taskfile = 1'b0;
    req_drive = 1'b0; req_words_m1 = 4'd3;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(wr_n == 1'b0, "R11", "pulse under way before reset", wr_n, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(wr_n == 1'b1 && rd_n == 1'b1, "R11", "strobes high after reset", {rd_n, wr_n}, 3);
    chk(req_ready == 1'b1, "R11", "ready after reset", req_ready, 1);
    begin
      int act_cnt;
      act_cnt = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (!rd_n || !wr_n || done) act_cnt++;
      end
      chk(act_cnt == 0, "R11", "activity after reset", act_cnt, 0);
    end

    summary();
    $finish;
  end

endmodule